// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block turns the core clock into the timing pulse that an I2C master's bus engine uses to step through the phases of each SCL period. The bus engine spends ten pulses on every SCL period. The resulting SCL rate is therefore the core clock divided by ten times the full division ratio.

The ratio comes from one 7-bit setting that holds two fields. A 4-bit linear factor M feeds a first counter that divides by M+1. A 3-bit exponent N feeds a second counter that divides the first counter's output by a further 2^(N+1). The tick period is (M+1)·2^(N+1) core cycles, so SCL = f_core / (10·(M+1)·2^(N+1)).

Loading a setting clears both counters, so every period after a change is a whole one. A synchronous soft reset puts the setting back to its default and restarts the counters in the same way.

Top module: `i2c_bitrate_div`

No state machine is used. A small decode selects one of three control actions in every cycle:
- RUN: count.
- LOAD: take the new setting and clear the counters.
- SOFT: restore the default and clear the counters.

SOFT wins over LOAD, and LOAD wins over RUN.

## Requirements
- R1: While `rst_n` is low, `baud_q` reads 0x44, which is M=8 and N=4, and `tick` is low.
- R2: A write with `baud_we` high and `soft_rst` low is captured on the next rising edge. Bits 6:3 of `baud_wdata` are M and bits 2:0 are N. `baud_q` holds its value whenever neither `baud_we` nor `soft_rst` is high.
- R3: In steady state, `tick` is a one-cycle pulse that repeats every (M+1)·2^(N+1) core cycles.
- R4: After the edge that captures a write, `tick` is first high in the P-th cycle that follows, where P = (M+1)·2^(N+1). It is never high in the first cycle after that edge.
- R5: `soft_rst` sets `baud_q` back to 0x44 and restarts the counters. When it is high in the same cycle as `baud_we`, the write has no effect.
- R6: After `rst_n` is released, the first tick arrives with the default period of 288 cycles, counting the cycle in which reset ends.
- R7: The extreme settings work: 0x00 gives a tick every 2 cycles, and 0x7F gives a tick every 4096 cycles.
- R8: Rewriting the same value in the middle of a period restarts that period from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restore of the default setting; has priority over a write |
| baud_we | input | 1 | Write strobe for the rate setting |
| baud_wdata | input | 7 | New setting: M in bits 6:3, N in bits 2:0 |
| baud_q | output | 7 | Current rate setting |
| tick | output | 1 | Single-cycle pulse, ten per SCL period |

## Verification
The hardest case to reach from the ports is a write that lands part-way through a period. In steady state the counters are always realigned to tick boundaries, so this case never arises on its own.

The stimulus waits a fixed number of cycles after a tick, then writes the value that is already loaded. The first tick must then come a full period after the write, not at the point where the old period would have ended. A soft reset issued in the same cycle as a write of a different value checks the priority between the two.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;
    localparam int BRG_M_W = 4;
    localparam int BRG_N_W = 3;
    localparam logic [BRG_M_W+BRG_N_W-1:0] BRG_BAUD_DEFAULT = 7'h44;

    // Per-cycle control action decoded from the register inputs
    typedef enum logic [1:0] {
        BRG_RUN  = 2'd0,
        BRG_LOAD = 2'd1,
        BRG_SOFT = 2'd2
    } brg_ctl_e;
endpackage

// File: rtl/brg_baud_reg.sv
module brg_baud_reg
    import i2c_brg_pkg::*;
#(
    parameter int M_W = BRG_M_W,
    parameter int N_W = BRG_N_W,
    parameter logic [M_W+N_W-1:0] BAUD_RST = BRG_BAUD_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               baud_we,
    input  logic [M_W+N_W-1:0] baud_wdata,
    output logic [M_W+N_W-1:0] baud_q,
    output logic [M_W-1:0]     m_val,
    output logic [N_W-1:0]     n_val,
    output brg_ctl_e           ctl
);
    localparam int BAUD_W = M_W + N_W;

    always_comb begin
        if (soft_rst)     ctl = BRG_SOFT;
        else if (baud_we) ctl = BRG_LOAD;
        else              ctl = BRG_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q <= BAUD_RST;
        end else begin
            unique case (ctl)
                BRG_SOFT: baud_q <= BAUD_RST;
                BRG_LOAD: baud_q <= baud_wdata;
                BRG_RUN:  baud_q <= baud_q;
                default:  baud_q <= baud_q;
            endcase
        end
    end

    assign m_val = baud_q[BAUD_W-1:N_W];
    assign n_val = baud_q[N_W-1:0];

    assert_soft_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (baud_q == BAUD_RST));
    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_we && !soft_rst) |=> (baud_q == $past(baud_wdata)));
    assert_hold_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_we && !soft_rst) |=> $stable(baud_q));
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [M_W-1:0] m_val,
    output logic           pre_en
);
    logic [M_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clear)          cnt <= '0;
        else if (cnt == m_val)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign pre_en = (cnt == m_val) && !clear;

    assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= m_val);
endmodule

// File: rtl/brg_expdiv.sv
module brg_expdiv #(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           pre_en,
    input  logic [N_W-1:0] n_val,
    output logic           tick
);
    localparam int EXP_W = 1 << N_W;

    logic [EXP_W-1:0] ecnt;
    logic [EXP_W-1:0] lim;

    // lim = 2^(n+1) - 1, formed without a wider intermediate
    assign lim = ~(({EXP_W{1'b1}} << n_val) << 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ecnt <= '0;
        else if (clear)   ecnt <= '0;
        else if (pre_en) begin
            if (ecnt == lim) ecnt <= '0;
            else             ecnt <= ecnt + 1'b1;
        end
    end

    assign tick = pre_en && (ecnt == lim);

    assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= lim);
endmodule

// File: rtl/i2c_bitrate_div.sv
module i2c_bitrate_div
    import i2c_brg_pkg::*;
#(
    parameter int M_W = BRG_M_W,
    parameter int N_W = BRG_N_W,
    parameter logic [M_W+N_W-1:0] BAUD_RST = BRG_BAUD_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               baud_we,
    input  logic [M_W+N_W-1:0] baud_wdata,
    output logic [M_W+N_W-1:0] baud_q,
    output logic               tick
);
    localparam int EXP_W = 1 << N_W;
    localparam int PER_W = M_W + EXP_W + 1;

    logic [M_W-1:0] m_val;
    logic [N_W-1:0] n_val;
    brg_ctl_e       ctl;
    logic           restart;
    logic           pre_en;

    brg_baud_reg #(.M_W(M_W), .N_W(N_W), .BAUD_RST(BAUD_RST)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .baud_we    (baud_we),
        .baud_wdata (baud_wdata),
        .baud_q     (baud_q),
        .m_val      (m_val),
        .n_val      (n_val),
        .ctl        (ctl)
    );

    assign restart = (ctl != BRG_RUN);

    brg_prescaler #(.M_W(M_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .m_val  (m_val),
        .pre_en (pre_en)
    );

    brg_expdiv #(.N_W(N_W)) u_exp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .pre_en (pre_en),
        .n_val  (n_val),
        .tick   (tick)
    );

    // Independent cycle count since the last tick or restart, used to
    // check the full period without a long $past window
    logic [PER_W-1:0] gap;
    logic [PER_W-1:0] period;

    assign period = ((PER_W'(m_val) + PER_W'(1)) << n_val) << 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap <= '0;
        else if (restart || tick)  gap <= '0;
        else                       gap <= gap + 1'b1;
    end

    assert_full_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == period - 1'b1));
    assert_tick_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
endmodule

// File: tb/i2c_bitrate_div_test.sv
`timescale 1ns/1ps
module i2c_bitrate_div_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       soft_rst;
    logic       baud_we;
    logic [6:0] baud_wdata;
    logic [6:0] baud_q;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_bitrate_div uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .baud_we    (baud_we),
        .baud_wdata (baud_wdata),
        .baud_q     (baud_q),
        .tick       (tick)
    );

    // {setting, expected period (M+1)*2^(N+1)}
    localparam logic [19:0] VEC [8] = '{
        {7'h00, 13'd2},     // M=0  N=0  (R7 minimum)
        {7'h7F, 13'd4096},  // M=15 N=7  (R7 maximum)
        {7'h08, 13'd4},     // M=1  N=0
        {7'h01, 13'd4},     // M=0  N=1
        {7'h44, 13'd288},   // M=8  N=4
        {7'h3A, 13'd64},    // M=7  N=2
        {7'h55, 13'd704},   // M=10 N=5
        {7'h7B, 13'd256}    // M=15 N=3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Counts falling edges until tick is seen high; clears strobes on the first
    task automatic measure(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            baud_we  = 1'b0;
            soft_rst = 1'b0;
            n++;
            if (tick || n >= 5000) break;
        end
    endtask

    task automatic do_write(input logic [6:0] v);
        @(negedge clk);
        baud_we    = 1'b1;
        baud_wdata = v;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; soft_rst = 1'b0; baud_we = 1'b0; baud_wdata = '0;
        repeat (3) @(negedge clk);
        check(baud_q == 7'h44, "R1 reset setting", baud_q, 7'h44);
        check(tick == 1'b0, "R1 tick low in reset", tick, 0);
        rst_n = 1'b1;               // released at a falling edge
        measure(n);                 // the release cycle counts as the first
        check(n == 287, "R6 first tick after reset", n, 287);
        measure(n);
        check(n == 288, "R3 default period", n, 288);

        for (int i = 0; i < 8; i++) begin
            logic [6:0] b;
            int p;
            b = VEC[i][19:13];
            p = int'(VEC[i][12:0]);
            do_write(b);
            measure(n);
            check(n == p, "R4 R7 first tick after write", n, p);
            check(baud_q == b, "R2 setting captured", baud_q, b);
            measure(n);
            check(n == p, "R3 R7 steady period", n, p);
        end

        // R8: same value rewritten part-way through a period
        do_write(7'h3A);
        measure(n);
        check(n == 64, "R4 first tick", n, 64);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check(tick == 1'b0, "R3 no early tick", tick, 0);
        end
        do_write(7'h3A);
        measure(n);
        check(n == 64, "R8 restart on rewrite", n, 64);

        // R5: soft reset wins over a simultaneous write
        do_write(7'h08);
        measure(n);
        check(n == 4, "R4 short period", n, 4);
        @(negedge clk);
        soft_rst   = 1'b1;
        baud_we    = 1'b1;
        baud_wdata = 7'h00;
        measure(n);
        check(baud_q == 7'h44, "R5 default restored, write ignored", baud_q, 7'h44);
        check(n == 288, "R5 restart after soft reset", n, 288);
        measure(n);
        check(n == 288, "R3 period after soft reset", n, 288);

        finish_run();
    end
endmodule